// File: doc/BRIEF.md
# Ethernet Transmit Start/End Bus Packer

The packer takes outgoing Ethernet frames as a byte stream with valid, ready and last flags. It packs them into 16-byte words for a wide transmit bus. Each word carries two start flags, one for each 8-byte half, and sixteen end flags, one for each byte lane. Bytes fill a word from the most significant lane downward. A frame may only begin at the top of a half. Its last byte is marked by a single end flag at that byte's lane. The far side accepts a finished word by raising an acknowledge input, and the word is held unchanged until it does.

An optional mode sends eight preamble bytes ahead of the destination address: seven bytes of 0x55 followed by 0xD5. The preamble fills exactly one half. A frame that ends in the upper half lets the next frame use the lower half of the same word, but only if that frame is already waiting. Otherwise the word is sent with a zero lower half. The block does not compute FCS, pad frames or insert gaps.

Top module: `txsb_packer`

## Requirements
- R1: After reset, tx_valid, tx_start, tx_end and tx_data are all zero, and in_ready is high while in_valid is low.
- R2: The k-th byte placed in a word sits in lane 15-k, that is tx_data[8(15-k)+7 : 8(15-k)]. Bytes of a frame follow each other without gaps, and a frame continues from lane 0 of one word into lane 15 of the next.
- R3: tx_start bit 1 is set in the word whose lanes 15..8 hold the first byte of a frame (or of its preamble), and tx_start bit 0 is set when that byte is in lane 7. No other start bits are set.
- R4: tx_end bit i (lane i, tx_data[8i+7:8i]) is set in the word holding a frame's last byte, at that byte's lane, and once per frame. Lanes after the last byte up to the next 8-byte boundary are zero.
- R5: If a frame's last byte lands in lanes 15..8 and the next frame's first byte is offered in the very next cycle, that frame starts at lane 7 of the same word. If no byte is offered in that cycle, the word is released with lanes 7..0 zero. A frame ending in lanes 7..0 releases its word, and the next frame starts at lane 15 of a fresh word.
- R6: While tx_valid is high and tx_ack is low, tx_valid, tx_data, tx_start and tx_end stay unchanged.
- R7: in_ready is low whenever tx_valid is high. Every accepted byte appears exactly once on the bus, in order.
- R8: With pre_en high when a frame's first byte is offered at a half boundary, the packer first fills that half with 0x55 in its upper seven lanes and 0xD5 in its lowest lane. in_ready is low during that cycle, and the frame's first byte follows at the top of the next half.
- R9: pre_en is looked at only when a frame begins; changing it during a frame has no effect on that frame.
- R10: A word presented with tx_ack high is released, and tx_valid is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Input byte is the last of its frame |
| in_ready | output | 1 | Packer accepts the offered byte this cycle |
| pre_en | input | 1 | Insert preamble ahead of the frame being started |
| tx_data | output | 128 | Packed word, lane i at bits 8i+7:8i |
| tx_start | output | 2 | Frame start flags: bit 1 upper half, bit 0 lower half |
| tx_end | output | 16 | One-hot end lane flags per frame |
| tx_valid | output | 1 | Word complete and waiting for acknowledge |
| tx_ack | input | 1 | Far side takes the presented word |

## Verification
The assertions assume that the byte source behaves like a stream: it holds in_data, in_last and in_valid until in_ready is seen. They also assume that each frame ends with in_last before the next begins, and that tx_ack matters only while a word is presented. The stimulus sets inputs only at the falling edge and waits for ready before moving on. It sweeps frame lengths 1 to 40 with the preamble on and off, with and without a gap cycle between frames, and toggles pre_en inside some frames. The acknowledge is a pseudo-random pattern with runs of low cycles, so every packing case is seen under backpressure.

// File: rtl/txsb_pkg.sv
package txsb_pkg;
   localparam int unsigned BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;
   localparam byte_t PRE_FILL = 8'h55;
   localparam byte_t SFD_CODE = 8'hD5;
   localparam int unsigned START_W = 2;

   function automatic int unsigned pos_width(input int unsigned lanes);
      return $clog2(lanes + 1);
   endfunction
endpackage

// File: rtl/txsb_ctrl.sv
module txsb_ctrl
   import txsb_pkg::*;
#(
   parameter int unsigned NLANES = 16,
   localparam int unsigned PW = pos_width(NLANES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               in_last,
   input  logic               pre_en,
   input  logic               tx_ack,
   output logic               in_ready,
   output logic [PW-1:0]      pos_o,
   output logic               wr_byte,
   output logic               wr_pre,
   output logic               clr,
   output logic               full_o,
   output logic [START_W-1:0] start_o
);
   localparam int unsigned HALF = NLANES / 2;
   localparam logic [PW-1:0] P_HALF = PW'(HALF);
   localparam logic [PW-1:0] P_FULL = PW'(NLANES);

   logic [PW-1:0]      pos_q;
   logic               in_frame_q;
   logic               full_q;
   logic [START_W-1:0] start_q;

   logic               at_bound;
   logic               pre_cyc;
   logic               accept;
   logic               closing;
   logic [PW-1:0]      pos_inc;
   logic [PW-1:0]      pos_round;
   logic [START_W-1:0] start_bit;

   always_comb begin
      at_bound  = !in_frame_q && (pos_q == '0 || pos_q == P_HALF);
      pre_cyc   = !full_q && at_bound && in_valid && pre_en;
      in_ready  = !full_q && !pre_cyc;
      accept    = in_valid && in_ready;
      closing   = !full_q && !in_frame_q && (pos_q == P_HALF) && !in_valid;
      pos_inc   = pos_q + 1'b1;
      pos_round = (pos_inc <= P_HALF) ? P_HALF : P_FULL;
      start_bit = (pos_q == '0) ? 2'b10 : 2'b01;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q      <= '0;
         in_frame_q <= 1'b0;
         full_q     <= 1'b0;
         start_q    <= '0;
      end else if (full_q) begin
         if (tx_ack) begin
            full_q  <= 1'b0;
            pos_q   <= '0;
            start_q <= '0;
         end
      end else if (pre_cyc) begin
         start_q    <= start_q | start_bit;
         in_frame_q <= 1'b1;
         pos_q      <= pos_q + P_HALF;
         full_q     <= (pos_q == P_HALF);
      end else if (accept) begin
         if (at_bound) start_q <= start_q | start_bit;
         in_frame_q <= !in_last;
         if (in_last) begin
            pos_q  <= pos_round;
            full_q <= (pos_round == P_FULL);
         end else begin
            pos_q  <= pos_inc;
            full_q <= (pos_inc == P_FULL);
         end
      end else if (closing) begin
         full_q <= 1'b1;
      end
   end

   assign pos_o   = pos_q;
   assign wr_byte = accept;
   assign wr_pre  = pre_cyc;
   assign clr     = full_q && tx_ack;
   assign full_o  = full_q;
   assign start_o = start_q;

   // R5: a half-open word with no waiting frame is released with its lower half empty
   a_r5_close_half: assert property (@(posedge clk) disable iff (!rst_n)
      closing |=> full_q && (pos_q == P_HALF) && !in_frame_q);

   // R8: after a preamble cycle the frame is open and the next byte goes to a fresh half
   a_r8_pre_opens: assert property (@(posedge clk) disable iff (!rst_n)
      pre_cyc |=> in_frame_q && (start_q != '0));
endmodule

// File: rtl/txsb_lane_dec.sv
module txsb_lane_dec
   import txsb_pkg::*;
#(
   parameter int unsigned NLANES = 16,
   localparam int unsigned PW = pos_width(NLANES)
) (
   input  logic [PW-1:0]     pos_i,
   output logic [NLANES-1:0] byte_sel,
   output logic [NLANES-1:0] half_sel
);
   localparam int unsigned HALF = NLANES / 2;

   for (genvar i = 0; i < NLANES; i++) begin : g_lane
      localparam logic [PW-1:0] MY_POS = PW'(NLANES - 1 - i);
      localparam bit IN_UPPER = (i >= HALF);
      assign byte_sel[i] = (pos_i == MY_POS);
      assign half_sel[i] = (pos_i == '0) ? IN_UPPER : !IN_UPPER;
   end
endmodule

// File: rtl/txsb_lanes.sv
module txsb_lanes
   import txsb_pkg::*;
#(
   parameter int unsigned NLANES = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     wr_byte,
   input  logic                     wr_pre,
   input  logic                     last,
   input  byte_t                    byte_in,
   input  logic [NLANES-1:0]        byte_sel,
   input  logic [NLANES-1:0]        half_sel,
   output logic [NLANES*BYTE_W-1:0] data_o,
   output logic [NLANES-1:0]        end_o
);
   localparam int unsigned HALF = NLANES / 2;

   for (genvar i = 0; i < NLANES; i++) begin : g_lane
      localparam bit IS_SFD = ((i % HALF) == 0);
      localparam byte_t PRE_BYTE = IS_SFD ? SFD_CODE : PRE_FILL;
      byte_t d_q;
      logic  e_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_q <= '0;
            e_q <= 1'b0;
         end else if (clr) begin
            d_q <= '0;
            e_q <= 1'b0;
         end else if (wr_pre && half_sel[i]) begin
            d_q <= PRE_BYTE;
         end else if (wr_byte && byte_sel[i]) begin
            d_q <= byte_in;
            e_q <= last;
         end
      end

      assign data_o[i*BYTE_W +: BYTE_W] = d_q;
      assign end_o[i] = e_q;
   end
endmodule

// File: rtl/txsb_packer.sv
module txsb_packer
   import txsb_pkg::*;
#(
   parameter int unsigned NLANES = 16,
   localparam int unsigned DW = NLANES * BYTE_W,
   localparam int unsigned PW = pos_width(NLANES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [BYTE_W-1:0]  in_data,
   input  logic               in_last,
   output logic               in_ready,
   input  logic               pre_en,
   output logic [DW-1:0]      tx_data,
   output logic [START_W-1:0] tx_start,
   output logic [NLANES-1:0]  tx_end,
   output logic               tx_valid,
   input  logic               tx_ack
);
   if (NLANES < 4 || (NLANES % 2) != 0) begin : g_bad_lanes
      $error("txsb_packer: NLANES must be even and at least 4");
   end

   logic [PW-1:0]     pos;
   logic              wr_byte;
   logic              wr_pre;
   logic              clr;
   logic [NLANES-1:0] byte_sel;
   logic [NLANES-1:0] half_sel;

   txsb_ctrl #(.NLANES(NLANES)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_last  (in_last),
      .pre_en   (pre_en),
      .tx_ack   (tx_ack),
      .in_ready (in_ready),
      .pos_o    (pos),
      .wr_byte  (wr_byte),
      .wr_pre   (wr_pre),
      .clr      (clr),
      .full_o   (tx_valid),
      .start_o  (tx_start)
   );

   txsb_lane_dec #(.NLANES(NLANES)) u_dec (
      .pos_i    (pos),
      .byte_sel (byte_sel),
      .half_sel (half_sel)
   );

   txsb_lanes #(.NLANES(NLANES)) u_lanes (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .wr_byte  (wr_byte),
      .wr_pre   (wr_pre),
      .last     (in_last),
      .byte_in  (in_data),
      .byte_sel (byte_sel),
      .half_sel (half_sel),
      .data_o   (tx_data),
      .end_o    (tx_end)
   );

   // R6: a presented word is frozen until acknowledged
   a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ack |=> tx_valid && $stable(tx_data) && $stable(tx_start) && $stable(tx_end));

   // R7: no byte is taken while a word waits
   a_r7_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !in_ready);

   // R10: an acknowledged word is gone in the next cycle
   a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ack |=> !tx_valid);

   // R4: one end per frame, at most one frame per half
   a_r4_end_limit: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> ($countones(tx_end) <= 2));
endmodule

// File: tb/tb_txsb_packer.sv
`timescale 1ns/1ps
module tb_txsb_packer;
   localparam int N = 16;
   localparam int HALF = N / 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic [7:0]     in_data = '0;
   logic           in_last = 1'b0;
   logic           in_ready;
   logic           pre_en = 1'b0;
   logic [N*8-1:0] tx_data;
   logic [1:0]     tx_start;
   logic [N-1:0]   tx_end;
   logic           tx_valid;
   logic           tx_ack = 1'b0;

   always #5 clk = ~clk;

   txsb_packer #(.NLANES(N)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .in_ready(in_ready), .pre_en(pre_en),
      .tx_data(tx_data), .tx_start(tx_start), .tx_end(tx_end),
      .tx_valid(tx_valid), .tx_ack(tx_ack)
   );

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit timeout = 1'b0;
   bit run_mon = 1'b0;
   int expected_words = 0;
   int consumed = 0;

   logic [N*8-1:0] q_data[$];
   logic [1:0]     q_start[$];
   logic [N-1:0]   q_end[$];

   logic [N*8-1:0] m_data;
   logic [1:0]     m_start;
   logic [N-1:0]   m_end;
   int             m_pos;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) timeout <= 1'b1;
   end

   function automatic logic [7:0] fbyte(input int fid, input int j);
      return 8'((fid * 29 + j * 7 + 1) & 255);
   endfunction

   task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic m_emit();
      q_data.push_back(m_data);
      q_start.push_back(m_start);
      q_end.push_back(m_end);
      expected_words++;
      m_data = '0; m_start = '0; m_end = '0; m_pos = 0;
   endtask

   task automatic m_put(input logic [7:0] b, input bit last);
      int lane;
      lane = N - 1 - m_pos;
      m_data[lane*8 +: 8] = b;
      m_pos++;
      if (last) begin
         m_end[lane] = 1'b1;
         m_pos = (m_pos <= HALF) ? HALF : N;
      end
      if (m_pos == N) m_emit();
   endtask

   // model of R2 R3 R4 R5 R8 built from the requirement text
   task automatic m_frame(input int len, input bit pre, input int gap_before, input int fid);
      if (m_pos == HALF && gap_before > 0) m_emit();
      m_start = m_start | ((m_pos == 0) ? 2'b10 : 2'b01);
      if (pre) begin
         for (int k = 0; k < HALF; k++)
            m_put((k == HALF - 1) ? 8'hD5 : 8'h55, 1'b0);
      end
      for (int j = 0; j < len; j++) m_put(fbyte(fid, j), j == len - 1);
   endtask

   task automatic send_frame(input int len, input bit pre, input int gap_before, input int fid, input bit wobble);
      m_frame(len, pre, gap_before, fid);
      for (int g = 0; g < gap_before; g++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_last = 1'b0;
      end
      for (int j = 0; j < len; j++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data = fbyte(fid, j);
         in_last = (j == len - 1);
         // R9: pre_en wobbles inside the frame; model uses the start value only
         if (j == 0) pre_en = pre;
         else if (wobble) pre_en = ~pre_en;
         #1;
         while (!in_ready && !timeout) begin
            @(negedge clk);
            #1;
         end
      end
   endtask

   // acknowledge pattern with runs of low cycles
   logic [15:0] lfsr = 16'hACE1;
   initial begin
      forever begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         tx_ack = lfsr[0] | lfsr[3];
      end
   end

   // output monitor
   logic           p_valid = 1'b0;
   logic           p_ack = 1'b0;
   logic [N*8-1:0] p_data = '0;
   logic [1:0]     p_start = '0;
   logic [N-1:0]   p_end = '0;
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (run_mon) begin
            if (tx_valid) chk(!in_ready, "R7 in_ready while word waits", 128'(in_ready), 128'(0));
            if (p_valid && !p_ack) begin
               chk(tx_valid == 1'b1, "R6 valid held", 128'(tx_valid), 128'(1));
               chk(tx_data == p_data, "R6 data held", tx_data, p_data);
               chk({tx_start, tx_end} == {p_start, p_end}, "R6 flags held",
                   128'({tx_start, tx_end}), 128'({p_start, p_end}));
            end
            if (p_valid && p_ack) chk(!tx_valid, "R10 release after ack", 128'(tx_valid), 128'(0));
            if (tx_valid && tx_ack) begin
               consumed++;
               if (q_data.size() == 0) begin
                  chk(1'b0, "R7 unexpected extra word", tx_data, 128'(0));
               end else begin
                  logic [N*8-1:0] ed;
                  logic [1:0]     es;
                  logic [N-1:0]   ee;
                  ed = q_data.pop_front();
                  es = q_start.pop_front();
                  ee = q_end.pop_front();
                  // data covers R2 R5 R8 R9 lane contents
                  chk(tx_data == ed, "R2 word data", tx_data, ed);
                  chk(tx_start == es, "R3 start flags", 128'(tx_start), 128'(es));
                  chk(tx_end == ee, "R4 end flags", 128'(tx_end), 128'(ee));
               end
            end
            p_valid = tx_valid; p_ack = tx_ack;
            p_data = tx_data; p_start = tx_start; p_end = tx_end;
         end
      end
   end

   initial begin
      int fid;
      m_data = '0; m_start = '0; m_end = '0; m_pos = 0;
      repeat (3) @(negedge clk);
      #2;
      // R1 reset state
      chk(tx_valid == 1'b0, "R1 tx_valid after reset", 128'(tx_valid), 128'(0));
      chk(tx_start == 2'b00 && tx_end == '0, "R1 flags after reset", 128'({tx_start, tx_end}), 128'(0));
      chk(tx_data == '0, "R1 data after reset", tx_data, 128'(0));
      chk(in_ready == 1'b1, "R1 in_ready idle", 128'(in_ready), 128'(1));
      rst_n = 1'b1;
      run_mon = 1'b1;
      fid = 0;
      // R5 directed: 8-byte frame then 19-byte frame back to back, end bit 5 in second word
      send_frame(8, 1'b0, 1, fid, 1'b0); fid++;
      send_frame(19, 1'b0, 0, fid, 1'b0); fid++;
      // R8 directed: preamble frame after a gap
      send_frame(6, 1'b1, 2, fid, 1'b0); fid++;
      // sweep over length, preamble mode and spacing
      for (int len = 1; len <= 40 && !timeout; len++) begin
         for (int pre = 0; pre < 2; pre++) begin
            for (int gap = 0; gap < 2; gap++) begin
               send_frame(len, pre[0], gap, fid, (fid % 3) == 0);
               fid++;
            end
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last = 1'b0;
      pre_en = 1'b0;
      if (m_pos == HALF) m_emit();
      while (q_data.size() != 0 && !timeout) @(negedge clk);
      repeat (3) @(negedge clk);
      // R7 every byte delivered exactly once: word counts agree
      chk(consumed == expected_words, "R7 word count", 128'(consumed), 128'(expected_words));
      if (timeout) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule